// File: doc/BRIEF.md
# Frame-Linear Video Timing Generator

This block produces horizontal sync, vertical sync and data-enable for a video panel, and drives the panel pixel bus. Horizontal timing is programmed in pixel clocks. Vertical timing is programmed as absolute pixel-clock counts measured from the start of the frame. Firmware obtains these counts by multiplying line numbers by the horizontal period. For this reason the block runs one frame-wide pixel counter next to the horizontal counter, and it decodes every vertical edge against that single counter.

Software writes timing through a simple write port. Each write lands in a live register. A shadow copy drives the counters and decoders, and it refreshes only at a frame boundary, or on every cycle while the block is disabled. When the active window needs a pixel and upstream has none, the block sends a programmable fill colour and sets a sticky underflow flag.

Top module: `frame_timing_gen`

## Requirements
- R1: Register addresses: 0 control (bit 0 = run enable), 1 horizontal timing (bits 31:16 period, bits 15:0 hsync width), 2 frame length in pixel clocks, 3 vsync width in pixel clocks, 4 horizontal window (bits 31:16 last column, bits 15:0 first column), 5 first active pixel count of the frame, 6 last active pixel count of the frame, 7 fill colour (low PIX_W bits), 8 underflow clear (any data).
- R2: While running, the horizontal counter steps from 0 to period-1 and wraps. hsync_o is high while the counter is below the hsync width.
- R3: While running, the frame counter steps from 0 to frame length-1 and wraps. Both counters restart at 0 on that wrap. vsync_o is high while the frame counter is below the vsync width.
- R4: de_o is high only when the horizontal counter lies in [first, last] and the frame counter lies in [first, last] of the vertical window. All bounds are inclusive.
- R5: While de_o is high, pix_o equals pix_i when pix_valid_i is high and equals the fill colour otherwise. While de_o is low, pix_o is zero.
- R6: underflow_o sets at the end of any cycle with de_o high and pix_valid_i low. It stays set until a write to address 8. A set in the same cycle as the clear wins.
- R7: Timing and fill writes made while running take effect from the first cycle of the next frame. Writes made while disabled take effect at once.
- R8: With enable clear, both counters hold at 0 and hsync_o, vsync_o, de_o and pix_o are low. After the write that sets enable, the first cycle has both counters at 0.
- R9: After reset, all registers are zero, enable is clear and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | 32 | Register write data |
| pix_i | input | PIX_W | Upstream pixel |
| pix_valid_i | input | 1 | Upstream pixel present |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| pix_o | output | PIX_W | Panel pixel |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that the programmed frame length is a whole multiple of a nonzero horizontal period. They also assume the window bounds lie inside the period and the frame, and that period and length are at least 2. Every configuration the stimulus writes meets these rules: a 10-clock line and a 6-line frame. Mid-frame writes are timed so that both the old and the new shadow values are seen across the frame boundary. The stimulus toggles pix_valid_i in a fixed pattern that falls inside and outside the window, so the flag is both set and cleared.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned H_W = 16;
  localparam int unsigned F_W = 32;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_HTIME = 4'd1;
  localparam logic [3:0] A_FLEN  = 4'd2;
  localparam logic [3:0] A_VPW   = 4'd3;
  localparam logic [3:0] A_HWIN  = 4'd4;
  localparam logic [3:0] A_VFIRST= 4'd5;
  localparam logic [3:0] A_VLAST = 4'd6;
  localparam logic [3:0] A_FILL  = 4'd7;
  localparam logic [3:0] A_UCLR  = 4'd8;

  typedef struct packed {
    logic [H_W-1:0] h_per;
    logic [H_W-1:0] h_pw;
    logic [H_W-1:0] h_first;
    logic [H_W-1:0] h_last;
    logic [F_W-1:0] f_len;
    logic [F_W-1:0] v_pw;
    logic [F_W-1:0] v_first;
    logic [F_W-1:0] v_last;
  } vtg_timing_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PIX_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              load_i,
  input  logic              ufl_set_i,
  output logic              en_o,
  output vtg_timing_t       tim_o,
  output logic [PIX_W-1:0]  fill_o,
  output logic              ufl_o
);
  vtg_timing_t      live_q;
  logic [PIX_W-1:0] live_fill_q;
  logic             ufl_clr;

  assign ufl_clr = wr_en_i && (wr_addr_i == ADDR_W'(A_UCLR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o        <= 1'b0;
      live_q      <= '0;
      live_fill_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_W'(A_CTRL):   en_o <= wr_data_i[0];
        ADDR_W'(A_HTIME):  {live_q.h_per, live_q.h_pw} <= wr_data_i;
        ADDR_W'(A_FLEN):   live_q.f_len <= wr_data_i;
        ADDR_W'(A_VPW):    live_q.v_pw <= wr_data_i;
        ADDR_W'(A_HWIN):   {live_q.h_last, live_q.h_first} <= wr_data_i;
        ADDR_W'(A_VFIRST): live_q.v_first <= wr_data_i;
        ADDR_W'(A_VLAST):  live_q.v_last <= wr_data_i;
        ADDR_W'(A_FILL):   live_fill_q <= wr_data_i[PIX_W-1:0];
        default: ;
      endcase
    end
  end

  // shadow copy used by counters and decode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_o  <= '0;
      fill_o <= '0;
    end else if (load_i) begin
      tim_o  <= live_q;
      fill_o <= live_fill_q;
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ufl_o <= 1'b0;
    else if (ufl_set_i) ufl_o <= 1'b1;
    else if (ufl_clr)   ufl_o <= 1'b0;
  end
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
  import vtg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  vtg_timing_t    tim_i,
  output logic [H_W-1:0] h_cnt_o,
  output logic [F_W-1:0] f_cnt_o,
  output logic           wrap_o
);
  assign wrap_o = en_i && (f_cnt_o == tim_i.f_len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt_o <= '0;
      f_cnt_o <= '0;
    end else if (!en_i || wrap_o) begin
      h_cnt_o <= '0;
      f_cnt_o <= '0;
    end else begin
      f_cnt_o <= f_cnt_o + 1'b1;
      h_cnt_o <= (h_cnt_o == tim_i.h_per - 1'b1) ? '0 : h_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/vtg_out.sv
module vtg_out
  import vtg_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic             en_i,
  input  logic [H_W-1:0]   h_cnt_i,
  input  logic [F_W-1:0]   f_cnt_i,
  input  vtg_timing_t      tim_i,
  input  logic [PIX_W-1:0] fill_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_valid_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             ufl_set_o
);
  logic h_in, v_in;

  assign h_in = (h_cnt_i >= tim_i.h_first) && (h_cnt_i <= tim_i.h_last);
  assign v_in = (f_cnt_i >= tim_i.v_first) && (f_cnt_i <= tim_i.v_last);

  assign hsync_o   = en_i && (h_cnt_i < tim_i.h_pw);
  assign vsync_o   = en_i && (f_cnt_i < tim_i.v_pw);
  assign de_o      = en_i && h_in && v_in;
  assign pix_o     = !de_o ? '0 : (pix_valid_i ? pix_i : fill_i);
  assign ufl_set_o = de_o && !pix_valid_i;
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PIX_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              pix_valid_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic              underflow_o
);
  vtg_timing_t      tim;
  logic [PIX_W-1:0] fill;
  logic             en, wrap, ufl_set;
  logic [H_W-1:0]   h_cnt;
  logic [F_W-1:0]   f_cnt;

  vtg_regs #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(!en || wrap), .ufl_set_i(ufl_set),
    .en_o(en), .tim_o(tim), .fill_o(fill), .ufl_o(underflow_o)
  );

  vtg_counters u_cnt (
    .clk_i, .rst_ni, .en_i(en), .tim_i(tim),
    .h_cnt_o(h_cnt), .f_cnt_o(f_cnt), .wrap_o(wrap)
  );

  vtg_out #(.PIX_W(PIX_W)) u_out (
    .en_i(en), .h_cnt_i(h_cnt), .f_cnt_i(f_cnt), .tim_i(tim), .fill_i(fill),
    .pix_i, .pix_valid_i, .hsync_o, .vsync_o, .de_o, .pix_o,
    .ufl_set_o(ufl_set)
  );

  assert_h_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tim.h_per != '0) |-> (h_cnt < tim.h_per));

  assert_frame_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && $past(en) && f_cnt != '0) |-> (f_cnt == $past(f_cnt) + 1'b1));

  assert_shadow_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && $past(en) && f_cnt != '0) |-> ($stable(tim) && $stable(fill)));

  assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (h_cnt == '0 && f_cnt == '0));

  assert_ufl_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && !pix_valid_i) |=> underflow_o);
endmodule

// File: tb/frame_timing_gen_tb.sv
`timescale 1ns/1ps
module frame_timing_gen_tb;
  localparam int PIX_W = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [3:0]       wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic [PIX_W-1:0] pix_in = '0;
  logic             pix_vld = 1'b1;
  logic             hs, vs, de, ufl;
  logic [PIX_W-1:0] pix_out;

  int checks = 0, fails = 0;
  int hper, hpw, hfirst, hlast, flen, vpw, vfirst, vlast, fill;
  int n_hpw, n_fill;
  bit pend = 0;
  bit ufl_exp = 0;

  always #2.5 clk = ~clk;

  frame_timing_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pix_i(pix_in), .pix_valid_i(pix_vld),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .pix_o(pix_out), .underflow_o(ufl)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle_checks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R8 hsync idle", 32'(hs), 0);
      chk("R8 vsync idle", 32'(vs), 0);
      chk("R8 de idle", 32'(de), 0);
      chk("R8 pix idle", 32'(pix_out), 0);
      chk("R6 flag held", 32'(ufl), 32'(ufl_exp));
    end
  endtask

  // starts in the cycle right after the enabling write
  task automatic run(int n, bit mid);
    for (int k = 0; k < n; k++) begin
      int f, h;
      bit e_de, vld, clr;
      logic [31:0] e_pix;
      if (k > 0 && k % flen == 0 && pend) begin
        hpw = n_hpw; fill = n_fill; pend = 0;   // R7 new frame uses new values
      end
      f = k % flen;
      h = f % hper;
      vld = (k % 7 != 3);
      pix_vld = vld;
      pix_in = PIX_W'(24'h100000 + k);
      wr_en = 1'b0;
      if (mid && k == 25) begin
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = {16'd10, 16'd4};
        n_hpw = 4; pend = 1;
      end
      if (mid && k == 30) begin
        wr_en = 1'b1; wr_addr = 4'd7; wr_data = 32'h0000FF00;
        n_fill = 32'h00FF00; pend = 1;
      end
      if (mid && k == 100) begin
        wr_en = 1'b1; wr_addr = 4'd8; wr_data = 32'h0;
      end
      clr = wr_en && wr_addr == 4'd8;
      e_de = (h >= hfirst) && (h <= hlast) && (f >= vfirst) && (f <= vlast);
      e_pix = !e_de ? 32'h0 : (vld ? 32'(pix_in) : 32'(fill));
      @(negedge clk);
      chk("R2 hsync", 32'(hs), 32'(h < hpw));
      chk("R3 vsync", 32'(vs), 32'(f < vpw));
      chk("R4 de", 32'(de), 32'(e_de));
      chk("R5 pix", 32'(pix_out), e_pix);
      chk("R6 underflow", 32'(ufl), 32'(ufl_exp));
      if (e_de && !vld) ufl_exp = 1;
      else if (clr) ufl_exp = 0;
      @(posedge clk); #1;
    end
    wr_en = 1'b0;
    pix_vld = 1'b1;
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R9 reset state
    #7;
    @(negedge clk);
    chk("R9 hsync rst", 32'(hs), 0);
    chk("R9 vsync rst", 32'(vs), 0);
    chk("R9 de rst", 32'(de), 0);
    chk("R9 pix rst", 32'(pix_out), 0);
    chk("R9 ufl rst", 32'(ufl), 0);
    rst_n = 1'b1;

    // R1 programming: 10-clock lines, 6 lines per frame
    hper = 10; hpw = 2; hfirst = 3; hlast = 8;
    flen = 60; vpw = 10; vfirst = 20; vlast = 49; fill = 0;
    wr(4'd1, {16'(hper), 16'(hpw)});
    wr(4'd2, 32'(flen));
    wr(4'd3, 32'(vpw));
    wr(4'd4, {16'(hlast), 16'(hfirst)});
    wr(4'd5, 32'(vfirst));
    wr(4'd6, 32'(vlast));
    wr(4'd7, 32'(fill));
    idle_checks(4);                      // R8 disabled after setup

    wr(4'd0, 32'h1);
    run(130, 1'b1);                      // R2..R7 with mid-frame writes

    wr(4'd0, 32'h0);
    idle_checks(6);                      // R8 disable

    wr(4'd4, {16'd9, 16'd0});            // R7 immediate while disabled
    hfirst = 0; hlast = 9;
    wr(4'd0, 32'h1);
    run(65, 1'b0);                       // R8 restart from zero

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule